// File: doc/BRIEF.md
# Base Address Window Decoder

This block works out which of a function's address windows an incoming access lands in. It has six base address registers and one expansion ROM window. It takes the live contents of the base registers, the size of each region, and whether each region is I/O or memory. It also takes the I/O-space and memory-space enable bits of the command register. For an access address and space type it returns, one cycle later, a hit flag, the index of the region that claimed the access, and the byte offset into that region.

The block also follows the effective mapping of every window, meaning its base and whether it is live at all. It pulses a strobe for one cycle whenever that mapping moves, so logic downstream can rebuild any cached routing. A write that leaves the effective mapping unchanged does not raise the strobe. Examples are a write to the low bits that sit inside a window, or a write to a window that is switched off.

Top module: `bar_window_decoder`

## Requirements
- R1: A region whose size input is zero never claims an access, whatever its base register holds.
- R2: Each region size is zero or a power of two. A live window starts at its register value with the low log2(size) bits forced to zero and ends at start plus size minus one. Addresses one below the start or one past the end miss.
- R3: A region marked I/O (its bit in `bar_is_io` is 1) claims only I/O accesses (`acc_is_io` = 1), and only while `cmd_io_en` is 1.
- R4: A memory region claims only memory accesses (`acc_is_io` = 0), and only while `cmd_mem_en` is 1.
- R5: The ROM window is always memory type. It claims an access only when `cmd_mem_en` is 1 and bit 0 of the ROM register is 1.
- R6: When several windows match, the lowest base register index wins. The ROM window loses to every base register.
- R7: `hit_idx` is 0 to 5 for the base registers and 6 for the ROM. `hit_off` is the access address minus the window start. On a miss, `hit`, `hit_idx` and `hit_off` are all zero.
- R8: Decode results are registered and appear one clock after the inputs. A synchronous active-high reset clears `hit`, `hit_idx`, `hit_off` and `remap`.
- R9: `remap` is high for exactly one cycle after a cycle in which some window's live state or start address changed. A disabled window counts as having no start address, so rewriting its register or toggling bits inside a live window's span leaves `remap` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bar_value | input | 7*ADDR_W | Region registers, region r in bits [r*ADDR_W +: ADDR_W]; region 6 is the ROM |
| region_size | input | 7*ADDR_W | Size of each region in bytes, same packing; zero means not implemented |
| bar_is_io | input | 6 | Per base register: 1 for I/O, 0 for memory |
| cmd_io_en | input | 1 | Command register I/O-space enable |
| cmd_mem_en | input | 1 | Command register memory-space enable |
| acc_addr | input | ADDR_W | Access address |
| acc_is_io | input | 1 | Access space: 1 for I/O, 0 for memory |
| hit | output | 1 | Registered: some window claimed the access |
| hit_idx | output | 3 | Registered index of the claiming region |
| hit_off | output | ADDR_W | Registered offset of the access within the window |
| remap | output | 1 | One-cycle pulse on a change of effective mapping |

## Verification
The decode is exercised with several kinds of access. Some land exactly on the first and last byte of a window and one byte outside each end, which separates a correct mask from one that is off by a bit. Some use an unaligned register value, which shows whether the low bits are cleared. Other accesses are sent with the matching space enable off, or with the wrong space type, which tells gating faults apart from type-match faults. Overlapping windows, including a base register laid over the ROM, expose the priority order. A scripted sequence of register and enable changes checks that `remap` rises for real moves only, and not for rewrites to disabled windows or to bits inside a window.

// File: rtl/bar_win_pkg.sv
package bar_win_pkg;
  typedef enum logic {
    SPACE_MEM = 1'b0,
    SPACE_IO  = 1'b1
  } space_e;

  localparam int unsigned BAR_COUNT = 6;
  localparam int unsigned RGN_COUNT = BAR_COUNT + 1;
  localparam int unsigned IDX_W     = $clog2(RGN_COUNT);
  localparam int unsigned ROM_IDX   = BAR_COUNT;
endpackage

// File: rtl/bar_win_region.sv
module bar_win_region
  import bar_win_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter bit          IS_ROM = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] size,
  input  logic              is_io,
  input  logic              cmd_io_en,
  input  logic              cmd_mem_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_is_io,
  output logic              live,
  output logic [ADDR_W-1:0] eff_base,
  output logic              match,
  output logic [ADDR_W-1:0] offset
);
  logic [ADDR_W-1:0] mask;
  logic              implemented;
  space_e            space;
  logic              space_on;

  assign mask        = ~(size - 1'b1);
  assign implemented = |size;

  generate
    if (IS_ROM) begin : g_rom
      assign space    = SPACE_MEM;
      assign space_on = cmd_mem_en & reg_val[0];
    end else begin : g_bar
      assign space    = is_io ? SPACE_IO : SPACE_MEM;
      assign space_on = is_io ? cmd_io_en : cmd_mem_en;
    end
  endgenerate

  assign live     = implemented & space_on;
  assign eff_base = live ? (reg_val & mask) : '0;
  assign match    = live && (space_e'(acc_is_io) == space)
                    && ((acc_addr & mask) == (reg_val & mask));
  assign offset   = acc_addr & ~mask;

  AST_SIZE_POW2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(size)); // R2

  AST_ZERO_SIZE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (size == '0) |-> (!match && eff_base == '0)); // R1
endmodule

// File: rtl/bar_win_prio.sv
module bar_win_prio #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned N      = 7,
  localparam int unsigned IW    = $clog2(N)
) (
  input  logic [N-1:0]        match,
  input  logic [N*ADDR_W-1:0] offsets,
  output logic                hit,
  output logic [IW-1:0]       idx,
  output logic [ADDR_W-1:0]   offset
);
  always_comb begin
    hit    = 1'b0;
    idx    = '0;
    offset = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (match[r]) begin
        hit    = 1'b1;
        idx    = IW'(r);
        offset = offsets[r*ADDR_W +: ADDR_W];
      end
    end
  end
endmodule

// File: rtl/bar_win_remap.sv
module bar_win_remap #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned N      = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        live,
  input  logic [N*ADDR_W-1:0] bases,
  output logic                strobe
);
  logic [N-1:0]        live_q;
  logic [N*ADDR_W-1:0] bases_q;
  logic                primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q   <= '0;
      bases_q  <= '0;
      strobe   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      live_q   <= live;
      bases_q  <= bases;
      strobe   <= (live != live_q) || (bases != bases_q);
      primed_q <= 1'b1;
    end
  end

  AST_STEADY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $stable(live) && $stable(bases)) |=> !strobe); // R9
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import bar_win_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned NR    = RGN_COUNT,
  localparam int unsigned NB    = BAR_COUNT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NR*ADDR_W-1:0] bar_value,
  input  logic [NR*ADDR_W-1:0] region_size,
  input  logic [NB-1:0]        bar_is_io,
  input  logic                 cmd_io_en,
  input  logic                 cmd_mem_en,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic                 acc_is_io,
  output logic                 hit,
  output logic [IDX_W-1:0]     hit_idx,
  output logic [ADDR_W-1:0]    hit_off,
  output logic                 remap
);
  logic [NR-1:0]        live;
  logic [NR-1:0]        match;
  logic [NR*ADDR_W-1:0] bases;
  logic [NR*ADDR_W-1:0] offsets;
  logic                 sel_hit;
  logic [IDX_W-1:0]     sel_idx;
  logic [ADDR_W-1:0]    sel_off;

  for (genvar r = 0; r < NR; r++) begin : g_rgn
    bar_win_region #(
      .ADDR_W (ADDR_W),
      .IS_ROM (r == ROM_IDX)
    ) u_rgn (
      .clk        (clk),
      .rst        (rst),
      .reg_val    (bar_value[r*ADDR_W +: ADDR_W]),
      .size       (region_size[r*ADDR_W +: ADDR_W]),
      .is_io      ((r < NB) ? bar_is_io[r % NB] : 1'b0),
      .cmd_io_en  (cmd_io_en),
      .cmd_mem_en (cmd_mem_en),
      .acc_addr   (acc_addr),
      .acc_is_io  (acc_is_io),
      .live       (live[r]),
      .eff_base   (bases[r*ADDR_W +: ADDR_W]),
      .match      (match[r]),
      .offset     (offsets[r*ADDR_W +: ADDR_W])
    );
  end

  bar_win_prio #(.ADDR_W(ADDR_W), .N(NR)) u_prio (
    .match   (match),
    .offsets (offsets),
    .hit     (sel_hit),
    .idx     (sel_idx),
    .offset  (sel_off)
  );

  bar_win_remap #(.ADDR_W(ADDR_W), .N(NR)) u_remap (
    .clk    (clk),
    .rst    (rst),
    .live   (live),
    .bases  (bases),
    .strobe (remap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit     <= 1'b0;
      hit_idx <= '0;
      hit_off <= '0;
    end else begin
      hit     <= sel_hit;
      hit_idx <= sel_idx;
      hit_off <= sel_off;
    end
  end

  AST_ROM_GATED: assert property (@(posedge clk) disable iff (rst)
    (hit && hit_idx == IDX_W'(ROM_IDX))
      |-> ($past(cmd_mem_en) && $past(bar_value[ROM_IDX*ADDR_W]))); // R5

  AST_IO_GATED: assert property (@(posedge clk) disable iff (rst)
    (hit && $past(acc_is_io)) |-> $past(cmd_io_en)); // R3

  AST_MEM_GATED: assert property (@(posedge clk) disable iff (rst)
    (hit && !$past(acc_is_io)) |-> $past(cmd_mem_en)); // R4

  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (hit_idx == '0 && hit_off == '0)); // R7

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    hit |-> (hit_idx <= IDX_W'(ROM_IDX))); // R7
endmodule

// File: tb/bar_window_decoder_bench.sv
`timescale 1ns/1ps
module bar_window_decoder_bench;
  localparam int AW = 32;
  localparam int NR = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NR*AW-1:0] bar_value   = '0;
  logic [NR*AW-1:0] region_size = '0;
  logic [5:0]       bar_is_io   = '0;
  logic             cmd_io_en   = 1'b0;
  logic             cmd_mem_en  = 1'b0;
  logic [AW-1:0]    acc_addr    = '0;
  logic             acc_is_io   = 1'b0;
  logic             hit;
  logic [2:0]       hit_idx;
  logic [AW-1:0]    hit_off;
  logic             remap;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bar_window_decoder #(.ADDR_W(AW)) u_bar_window_decoder (
    .clk(clk), .rst(rst), .bar_value(bar_value), .region_size(region_size),
    .bar_is_io(bar_is_io), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
    .acc_addr(acc_addr), .acc_is_io(acc_is_io), .hit(hit), .hit_idx(hit_idx),
    .hit_off(hit_off), .remap(remap)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic e_hit, int e_idx, logic [AW-1:0] e_off,
                     int e_strb);
    checks++;
    if (hit !== e_hit || hit_idx !== 3'(e_idx) || hit_off !== e_off ||
        (e_strb >= 0 && remap !== 1'(e_strb))) begin
      errors++;
      $display("FAIL %s: got hit=%0b idx=%0d off=%h remap=%0b exp hit=%0b idx=%0d off=%h remap=%0d",
               req, hit, hit_idx, hit_off, remap, e_hit, e_idx, e_off, e_strb);
    end
  endtask

  task automatic set_rgn(int r, logic [AW-1:0] val, logic [AW-1:0] sz, logic io);
    bar_value[r*AW +: AW]   = val;
    region_size[r*AW +: AW] = sz;
    if (r < 6) bar_is_io[r] = io;
  endtask

  task automatic clear_cfg();
    bar_value = '0; region_size = '0; bar_is_io = '0;
    cmd_io_en = 1'b0; cmd_mem_en = 1'b0; acc_is_io = 1'b0; acc_addr = '0;
  endtask

  task automatic access(logic [AW-1:0] a, logic io);
    acc_addr = a; acc_is_io = io;
  endtask

  task automatic t_reset();
    set_rgn(0, 32'h0, 32'h100, 1'b0); cmd_mem_en = 1'b1;
    step();
    chk("R8 reset clears outputs", 1'b0, 0, '0, 0);
    @(negedge clk); rst = 1'b0;
    step();
    chk("R8 first decode after reset", 1'b1, 0, '0, -1);
    clear_cfg(); step();
  endtask

  task automatic t_unimpl();
    clear_cfg(); cmd_mem_en = 1'b1; cmd_io_en = 1'b1;
    set_rgn(0, 32'h0, 32'h0, 1'b0);
    access(32'h0, 1'b0); step();
    chk("R1 zero size memory region", 1'b0, 0, '0, -1);
    set_rgn(1, 32'h0000_0400, 32'h0, 1'b1);
    access(32'h0000_0400, 1'b1); step();
    chk("R1 zero size io region", 1'b0, 0, '0, -1);
  endtask

  task automatic t_bounds();
    clear_cfg(); cmd_mem_en = 1'b1;
    set_rgn(3, 32'h0000_5A0F, 32'h100, 1'b0);
    access(32'h0000_5A00, 1'b0); step();
    chk("R2 first byte, unaligned register", 1'b1, 3, 32'h0, -1);
    access(32'h0000_5AFF, 1'b0); step();
    chk("R2 last byte", 1'b1, 3, 32'hFF, -1);
    access(32'h0000_5B00, 1'b0); step();
    chk("R2 one past end", 1'b0, 0, '0, -1);
    access(32'h0000_59FF, 1'b0); step();
    chk("R2 one below start", 1'b0, 0, '0, -1);
    access(32'h0000_5A80, 1'b0); step();
    chk("R7 offset is address minus start", 1'b1, 3, 32'h80, -1);
  endtask

  task automatic t_io();
    clear_cfg();
    set_rgn(4, 32'h0000_C001, 32'h20, 1'b1);
    cmd_io_en = 1'b1; access(32'h0000_C01F, 1'b1); step();
    chk("R3 io window hit", 1'b1, 4, 32'h1F, -1);
    cmd_io_en = 1'b0; step();
    chk("R3 io enable off", 1'b0, 0, '0, -1);
    cmd_mem_en = 1'b1; access(32'h0000_C01F, 1'b0); step();
    chk("R3 memory access to io window", 1'b0, 0, '0, -1);
  endtask

  task automatic t_mem();
    clear_cfg();
    set_rgn(5, 32'h8000_0000, 32'h1000, 1'b0);
    access(32'h8000_0ABC, 1'b0); step();
    chk("R4 memory enable off", 1'b0, 0, '0, -1);
    cmd_mem_en = 1'b1; step();
    chk("R4 memory window hit", 1'b1, 5, 32'hABC, -1);
    cmd_io_en = 1'b1; access(32'h8000_0ABC, 1'b1); step();
    chk("R4 io access to memory window", 1'b0, 0, '0, -1);
  endtask

  task automatic t_rom();
    clear_cfg(); cmd_mem_en = 1'b1;
    set_rgn(6, 32'h000C_0000, 32'h800, 1'b0);
    access(32'h000C_0010, 1'b0); step();
    chk("R5 rom enable bit clear", 1'b0, 0, '0, -1);
    set_rgn(6, 32'h000C_0001, 32'h800, 1'b0); step();
    chk("R5 rom enabled", 1'b1, 6, 32'h10, -1);
    cmd_mem_en = 1'b0; step();
    chk("R5 rom without memory enable", 1'b0, 0, '0, -1);
    cmd_io_en = 1'b1; access(32'h000C_0010, 1'b1); step();
    chk("R5 rom ignores io access", 1'b0, 0, '0, -1);
  endtask

  task automatic t_prio();
    clear_cfg(); cmd_mem_en = 1'b1;
    set_rgn(0, 32'h1000_0000, 32'h1000_0000, 1'b0);
    set_rgn(1, 32'h1000_0000, 32'h1000, 1'b0);
    access(32'h1000_0010, 1'b0); step();
    chk("R6 lower index wins", 1'b1, 0, 32'h10, -1);
    set_rgn(0, 32'h1000_0000, 32'h0, 1'b0); step();
    chk("R6 next index after removal", 1'b1, 1, 32'h10, -1);
    set_rgn(2, 32'h2000_0000, 32'h1_0000, 1'b0);
    set_rgn(6, 32'h2000_0001, 32'h1_0000, 1'b0);
    access(32'h2000_0044, 1'b0); step();
    chk("R6 base register beats rom", 1'b1, 2, 32'h44, -1);
    set_rgn(2, 32'h2000_0000, 32'h0, 1'b0); step();
    chk("R6 rom when alone", 1'b1, 6, 32'h44, -1);
  endtask

  task automatic t_remap();
    clear_cfg(); step(); step();
    chk("R9 quiet when steady", 1'b0, 0, '0, 0);
    cmd_mem_en = 1'b1; step();
    chk("R9 enable with nothing implemented", 1'b0, 0, '0, 0);
    set_rgn(5, 32'h4000_0000, 32'h1000, 1'b0); step();
    chk("R9 window appears", 1'b0, 0, '0, 1);
    step();
    chk("R9 single cycle pulse", 1'b0, 0, '0, 0);
    set_rgn(5, 32'h4000_8000, 32'h1000, 1'b0); step();
    chk("R9 base moved", 1'b0, 0, '0, 1);
    set_rgn(5, 32'h4000_8FF0, 32'h1000, 1'b0); step();
    chk("R9 bits inside window", 1'b0, 0, '0, 0);
    cmd_mem_en = 1'b0; step();
    chk("R9 window disabled", 1'b0, 0, '0, 1);
    set_rgn(5, 32'h5000_0000, 32'h1000, 1'b0); step();
    chk("R9 rewrite while disabled", 1'b0, 0, '0, 0);
    cmd_mem_en = 1'b1; step();
    chk("R9 window re-enabled", 1'b0, 0, '0, 1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_unimpl();
    t_bounds();
    t_io();
    t_mem();
    t_rom();
    t_prio();
    t_remap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule